// File: doc/BRIEF.md
# Multiplexed Bus Memory Target

This block is a main-memory target on a parallel bus. The same wires carry the address in one phase and the data in another. The initiator marks each phase with three signals: a valid strobe, a phase-type bit (address or data) and a write flag.

On a read, the target captures the address from the bus and looks up the word in its synchronous storage array. In the following cycle it drives that word back onto the bus with its output enable raised, and the initiator captures it there.

On a write, the target keeps the captured address in a holding register. It then waits for the initiator to deliver the data word in a later phase, and stores that word at the held address. Idle cycles may come between the two phases. A new address phase that arrives before the data has come cancels the waiting write, and a one-cycle status pulse reports the loss.

The shared wires are modelled as three separate signals: an input copy of the bus, an output word and an output enable. The chip-level pad or tristate logic combines them.

Top module: `mbt_target`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_oe`, `rdata_vld` and `wr_dropped` are 0, `bus_out` is all zeros, and no write is waiting.
- R2: A read address phase (`ph_valid`=1, `ph_data`=0, `ph_write`=0) in cycle T causes the target to drive, in cycle T+1 only, the stored word at that address on `bus_out`, with `bus_oe`=1 and `rdata_vld`=1.
- R3: In every cycle that is not a read-return cycle, `bus_oe` and `rdata_vld` are 0 and `bus_out` is all zeros.
- R4: A write address phase (`ph_valid`=1, `ph_data`=0, `ph_write`=1) holds the address. A later write data phase (`ph_valid`=1, `ph_data`=1, `ph_write`=1) stores the `bus_in` word at the held address, and a later read of that address returns it.
- R5: A write data phase that arrives while no write is waiting leaves the storage unchanged.
- R6: A data phase with `ph_write`=0 is ignored. It neither stores a word nor cancels a waiting write.
- R7: A write address phase that arrives while a write is waiting replaces the held address. `wr_dropped` is 1 for exactly the next cycle. The next data word goes to the new address, and the old address keeps its earlier contents.
- R8: A read address phase that arrives while a write is waiting is served normally and cancels the waiting write. `wr_dropped` is 1 in the next cycle, and a data phase after that stores nothing.
- R9: Only the low AW bits of the bus are used as the word address, so addresses that differ only above bit AW-1 select the same word.
- R10: Idle cycles (`ph_valid`=0) between a write address phase and its data phase neither cancel nor alter the waiting write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ph_valid | input | 1 | A bus phase is present this cycle |
| ph_data | input | 1 | Phase type: 0 address, 1 data |
| ph_write | input | 1 | Transaction direction: 1 write, 0 read |
| bus_in | input | DW | Value seen on the shared address/data lines |
| bus_out | output | DW | Word the target drives during a read return, zero otherwise |
| bus_oe | output | 1 | Target output enable for the shared lines |
| rdata_vld | output | 1 | Read-return word is present on `bus_out` |
| wr_dropped | output | 1 | One-cycle pulse: a waiting write was cancelled by a new address phase |

## Verification
A wrong held address or a stuck pending flag does not show up on the cycle it goes wrong. It appears only when the data phase arrives and the word lands in the wrong place, so it is exposed by the next read-back of both the intended and the neighbouring addresses. A mistimed output enable or return word differs at the ports one cycle after the read address phase. A missing or extra cancellation pulse differs one cycle after the address phase that caused it. The reference model is compared against the ports on every cycle, so a mismatch in enable, word or pulse is caught in the cycle it occurs. A misplaced write is caught at the first later read of either address involved.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  // Decoded kind of the current bus phase
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RADDR  = 3'd1,
    PH_WADDR  = 3'd2,
    PH_WDATA  = 3'd3,
    PH_IGNORE = 3'd4
  } phase_e;

endpackage

// File: rtl/mbt_phase_decode.sv
module mbt_phase_decode
  import mbt_pkg::*;
(
  input  logic   ph_valid,
  input  logic   ph_data,
  input  logic   ph_write,
  output phase_e phase
);

  always_comb begin
    phase = PH_IDLE;
    if (ph_valid) begin
      unique case ({ph_data, ph_write})
        2'b00:   phase = PH_RADDR;
        2'b01:   phase = PH_WADDR;
        2'b11:   phase = PH_WDATA;
        default: phase = PH_IGNORE;  // read-type data phase: not a target action
      endcase
    end
  end

endmodule

// File: rtl/mbt_addr_hold.sv
module mbt_addr_hold
  import mbt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase,
  input  logic [AW-1:0] addr_in,
  output logic          pend_vld,
  output logic [AW-1:0] pend_addr,
  output logic          commit,
  output logic          drop_q
);

  logic          pend_nxt;
  logic          drop_nxt;
  logic          addr_en;

  // next-state
  always_comb begin
    pend_nxt = pend_vld;
    drop_nxt = 1'b0;
    addr_en  = 1'b0;
    commit   = 1'b0;
    unique case (phase)
      PH_RADDR: begin
        drop_nxt = pend_vld;
        pend_nxt = 1'b0;
      end
      PH_WADDR: begin
        drop_nxt = pend_vld;
        pend_nxt = 1'b1;
        addr_en  = 1'b1;
      end
      PH_WDATA: begin
        commit   = pend_vld;
        pend_nxt = 1'b0;
      end
      default: ;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      pend_vld <= pend_nxt;
      drop_q   <= drop_nxt;
    end
  end

  // held address: datapath, enable only
  always_ff @(posedge clk) begin
    if (addr_en) pend_addr <= addr_in;
  end

  assert_drop_on_readdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && phase == PH_RADDR) |=> (drop_q && !pend_vld));

  assert_drop_on_waddr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && phase == PH_WADDR) |=> (drop_q && pend_vld));

  assert_drop_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> $past(pend_vld));

  assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend_vld);

  assert_idle_keeps_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vld && phase == PH_IDLE) |=> (pend_vld && $stable(pend_addr)));

endmodule

// File: rtl/mbt_store_array.sv
module mbt_store_array #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/mbt_read_return.sv
module mbt_read_return #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_start,
  input  logic [DW-1:0] rd_q,
  output logic          ret_oe,
  output logic [DW-1:0] ret_word
);

  logic oe_nxt;

  always_comb oe_nxt = rd_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ret_oe <= 1'b0;
    else        ret_oe <= oe_nxt;
  end

  always_comb ret_word = ret_oe ? rd_q : '0;

  assert_return_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> ret_oe);

  assert_oe_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_oe |-> $past(rd_start));

  assert_return_single_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_oe && !rd_start) |=> !ret_oe);

endmodule

// File: rtl/mbt_target.sv
module mbt_target
  import mbt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph_valid,
  input  logic          ph_data,
  input  logic          ph_write,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          rdata_vld,
  output logic          wr_dropped
);

  phase_e        phase;
  logic [AW-1:0] bus_addr;
  logic          pend_vld;
  logic [AW-1:0] pend_addr;
  logic          commit;
  logic          rd_start;
  logic [DW-1:0] rd_q;
  logic          ret_oe;

  assign bus_addr = bus_in[AW-1:0];
  assign rd_start = (phase == PH_RADDR);

  mbt_phase_decode u_dec (
    .ph_valid (ph_valid),
    .ph_data  (ph_data),
    .ph_write (ph_write),
    .phase    (phase)
  );

  mbt_addr_hold #(.AW(AW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .addr_in   (bus_addr),
    .pend_vld  (pend_vld),
    .pend_addr (pend_addr),
    .commit    (commit),
    .drop_q    (wr_dropped)
  );

  mbt_store_array #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (pend_addr),
    .wr_data (bus_in),
    .rd_en   (rd_start),
    .rd_addr (bus_addr),
    .rd_q    (rd_q)
  );

  mbt_read_return #(.DW(DW)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_start (rd_start),
    .rd_q     (rd_q),
    .ret_oe   (ret_oe),
    .ret_word (bus_out)
  );

  assign bus_oe    = ret_oe;
  assign rdata_vld = ret_oe;

  assert_write_phase_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_write) |=> !bus_oe);

  assert_quiet_bus_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));

  assert_ignored_phase_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |=> ($stable(pend_vld) && !wr_dropped));

endmodule

// File: tb/sim_mbt_target.sv
module sim_mbt_target;

  localparam int  DW         = 32;
  localparam int  AW         = 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk;
  logic          rst_n;
  logic          ph_valid, ph_data, ph_write;
  logic [DW-1:0] bus_in;
  logic [DW-1:0] bus_out;
  logic          bus_oe, rdata_vld, wr_dropped;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  mbt_target #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ph_valid(ph_valid), .ph_data(ph_data), .ph_write(ph_write),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .rdata_vld(rdata_vld), .wr_dropped(wr_dropped)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [DW-1:0] ref_mem [int];
  bit            ref_pend;
  int            ref_paddr;
  logic          exp_oe, exp_drop;
  logic [DW-1:0] exp_word;

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(input bit in_rst);
    int a;
    exp_oe   = 1'b0;
    exp_drop = 1'b0;
    exp_word = '0;
    if (in_rst) begin
      ref_pend = 0;
      return;
    end
    a = int'(bus_in) & ((1 << AW) - 1);
    if (ph_valid) begin
      if (!ph_data) begin
        if (ref_pend) exp_drop = 1'b1;
        ref_pend = 0;
        if (ph_write) begin
          ref_pend  = 1;
          ref_paddr = a;
        end else begin
          exp_oe   = 1'b1;
          exp_word = ref_mem.exists(a) ? ref_mem[a] : 'x;
        end
      end else if (ph_write && ref_pend) begin
        ref_mem[ref_paddr] = bus_in;
        ref_pend = 0;
      end
    end
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic v, input logic d, input logic w,
                      input logic [DW-1:0] val, input string tag);
    ph_valid = v; ph_data = d; ph_write = w; bus_in = val;
    @(posedge clk);
    model_edge(!rst_n);
    @(negedge clk);
    chk(tag, "bus_oe",     {{(DW-1){1'b0}}, bus_oe},     {{(DW-1){1'b0}}, exp_oe});
    chk(tag, "rdata_vld",  {{(DW-1){1'b0}}, rdata_vld},  {{(DW-1){1'b0}}, exp_oe});
    chk(tag, "wr_dropped", {{(DW-1){1'b0}}, wr_dropped}, {{(DW-1){1'b0}}, exp_drop});
    if (!(exp_oe && $isunknown(exp_word)))
      chk(tag, "bus_out", bus_out, exp_word);
  endtask

  task automatic idle(input string tag);                     step(1'b0, 1'b0, 1'b0, '0, tag); endtask
  task automatic waddr(input int a, input string tag);       step(1'b1, 1'b0, 1'b1, DW'(a), tag); endtask
  task automatic wdata(input logic [DW-1:0] d, input string tag); step(1'b1, 1'b1, 1'b1, d, tag); endtask
  task automatic rdphase(input logic [DW-1:0] d, input string tag); step(1'b1, 1'b1, 1'b0, d, tag); endtask
  task automatic raddr(input int a, input string tag);
    step(1'b1, 1'b0, 1'b0, DW'(a), tag);
    idle(tag);  // return cycle: initiator releases the lines
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ph_valid = 1'b0; ph_data = 1'b0; ph_write = 1'b0; bus_in = '0;
    ref_pend = 0;
    @(negedge clk);
    // R1: reset state, including a read attempted under reset
    step(1'b1, 1'b0, 1'b0, 32'h5, "R1");
    idle("R1");
    rst_n = 1'b1;
    idle("R1");

    // R4 basic write then read, R2 timing
    waddr(5, "R4");
    wdata(32'hA5A5_0001, "R4");
    raddr(5, "R2");
    idle("R3");

    // R10 idle gaps, R6 read-type data phase ignored
    waddr(9, "R10");
    idle("R10");
    idle("R10");
    rdphase(32'hDEAD_BEEF, "R6");
    idle("R10");
    wdata(32'h0000_0909, "R6");
    raddr(9, "R6");

    // R5 orphan data phase
    wdata(32'hFFFF_FFFF, "R5");
    raddr(5, "R5");
    raddr(9, "R5");

    // R7 address replaces pending write
    waddr(20, "R7"); wdata(32'hC0C0_0020, "R7");
    waddr(20, "R7");
    waddr(21, "R7");
    wdata(32'hB0B0_0021, "R7");
    raddr(20, "R7");
    raddr(21, "R7");

    // R8 read cancels waiting write
    waddr(30, "R8"); wdata(32'hE0E0_0030, "R8");
    waddr(30, "R8");
    raddr(5, "R8");
    wdata(32'h1111_2222, "R8");
    raddr(30, "R8");

    // R9 upper address bits ignored
    waddr(32'h0000_0107, "R9");
    wdata(32'hF7F7_0007, "R9");
    raddr(7, "R9");
    raddr(32'h00AB_0207, "R9");

    // R2 back-to-back reads with no idle between the return and next address
    for (int i = 0; i < 8; i++) begin
      waddr(40 + i, "R4");
      wdata(32'h4000_0000 + i * 32'h0101_0101, "R4");
    end
    for (int i = 7; i >= 0; i--) raddr(40 + i, "R2");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, DW'(40 + i), "R2");
    idle("R3");

    // boundary addresses
    waddr(0, "R4");   wdata(32'h0, "R4");
    waddr(255, "R4"); wdata(32'hFFFF_FFFF, "R4");
    raddr(0, "R4");
    raddr(255, "R4");
    idle("R3");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule